// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer Counter with Prescaler

This block is the counting core of a microcontroller-style timer peripheral. A control word sets the count mode (halted, count up to a period limit, free-running, or count up then down), picks one of two clock-enable inputs (a fast and a slow domain), and sets a power-of-two input divider. Two further control bits request a clear and enable the overflow interrupt. The period limit is the channel 0 compare value and comes in from the compare logic outside the block.

Software reads and writes the control word and the counter through plain word ports. The block provides the live count, a one-cycle period-end pulse for the channel 0 flag logic, an overflow flag, and that flag gated by its enable. Software clears the flag by writing the control word with the flag bit at 0.

Top module: `tmr16_core`

## Requirements
- R1: Control bits [1:0] select the mode: 00 halted, 01 up to limit, 10 free-running, 11 up/down. In the halted mode the count never changes on ticks.
- R2: In up mode a qualified tick at a count at or above a nonzero limit returns the count to 0. On that tick the overflow flag sets and `period_pulse` is high for one cycle. Any other tick adds 1.
- R3: In up mode and in up/down mode a limit of 0 holds the count at 0. In free-running mode a limit of 0 has no effect.
- R4: In free-running mode a tick at 0xFFFF wraps the count to 0 and sets the overflow flag.
- R5: In up/down mode the count rises to the limit and then falls to 0. The tick that reaches the limit pulses `period_pulse`, and the tick that reaches 0 sets the overflow flag. The direction turns at each end.
- R6: Control bits [4:3] = d divide the selected tick stream by 2^d, so 80 ticks give 80, 40, 20 or 10 counts.
- R7: Control bit 2 picks the tick source (0 fast, 1 slow). Ticks on the other input have no effect.
- R8: Writing the control word with bit 5 set zeroes the count, the divider phase and the up/down direction. Bit 5 always reads back as 0.
- R9: A counter write loads the count directly and takes priority over a tick in the same cycle.
- R10: Every control write zeroes the divider phase. Bit 7 is the overflow flag and a write loads it. Bit 6 is the interrupt enable, and `ovf_irq` equals flag AND enable. The readback is {8'b0, flag, enable, 0, divider, source, mode}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_tick | input | 1 | Fast-domain clock enable |
| slow_tick | input | 1 | Slow-domain clock enable |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | CW | Counter write data |
| limit | input | CW | Channel 0 compare value used as period limit |
| count | output | CW | Current count |
| ctl_rdata | output | 16 | Control word readback |
| period_pulse | output | 1 | One-cycle pulse at period end |
| ovf_flag | output | 1 | Overflow flag |
| ovf_irq | output | 1 | Overflow flag gated by its enable |

## Verification
The bench targets the ends of the count range. If a design compares with the wrong bound in up mode, the period runs one tick long or short. If it ignores a zero limit, the count escapes 0 in up or up/down mode. A free-running counter that checks the limit would freeze at zero limit. The up/down turn points are checked tick by tick, which exposes a double count at the limit or a missed flag at 0. Divider runs on both sources catch phase that is not reset on clear and ticks leaking in from the unselected input. Randomised writes that collide with ticks check that a counter write wins over a tick.

// File: rtl/tmr16_core.sv
module tmr16_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fast_tick,
  input  logic          slow_tick,
  input  logic          ctl_wr,
  input  logic [15:0]   ctl_wdata,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] count,
  output logic [15:0]   ctl_rdata,
  output logic          period_pulse,
  output logic          ovf_flag,
  output logic          ovf_irq
);
  localparam int DIVW = 2;
  localparam int PW = (1 << DIVW) - 1;
  localparam logic [PW-1:0] PH_ALL = '1;
  localparam logic [1:0] M_STOP = 2'b00, M_UP = 2'b01, M_CONT = 2'b10, M_UPDN = 2'b11;

  logic [1:0]      mode_q;
  logic            src_q, ie_q, ovf_q, dir_q, pulse_q;
  logic [DIVW-1:0] div_q;
  logic [PW-1:0]   ph_q, ph_top;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic            dir_n, ovf_set, top_hit, tick;
  logic            unused_hi;

  assign unused_hi = ^ctl_wdata[15:8];
  assign tick = src_q ? slow_tick : fast_tick;
  assign ph_top = PH_ALL >> (PW - int'(div_q));

  always_comb begin
    cnt_n = cnt_q;
    dir_n = dir_q;
    ovf_set = 1'b0;
    top_hit = 1'b0;
    case (mode_q)
      M_UP:
        if (limit == '0) cnt_n = '0;
        else if (cnt_q >= limit) begin
          cnt_n = '0;
          ovf_set = 1'b1;
          top_hit = 1'b1;
        end else cnt_n = cnt_q + CW'(1);
      M_CONT: begin
        cnt_n = cnt_q + CW'(1);
        ovf_set = &cnt_q;
      end
      M_UPDN:
        if (limit == '0) begin
          cnt_n = '0;
          dir_n = 1'b0;
        end else if (!dir_q) begin
          if (cnt_q >= limit) begin
            cnt_n = cnt_q - CW'(1);
            ovf_set = (cnt_q == CW'(1));
            dir_n = (cnt_q != CW'(1));
          end else begin
            cnt_n = cnt_q + CW'(1);
            top_hit = (cnt_q + CW'(1) == limit);
          end
        end else if (cnt_q == '0) dir_n = 1'b0;
        else begin
          cnt_n = cnt_q - CW'(1);
          if (cnt_q == CW'(1)) begin
            ovf_set = 1'b1;
            dir_n = 1'b0;
          end
        end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_STOP; src_q <= 1'b0; div_q <= '0; ie_q <= 1'b0;
      ovf_q <= 1'b0; dir_q <= 1'b0; ph_q <= '0; cnt_q <= '0; pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (ctl_wr) begin
        mode_q <= ctl_wdata[1:0];
        src_q  <= ctl_wdata[2];
        div_q  <= ctl_wdata[3 +: DIVW];
        ie_q   <= ctl_wdata[6];
        ovf_q  <= ctl_wdata[7];
        ph_q   <= '0;
        if (ctl_wdata[5]) begin
          cnt_q <= '0;
          dir_q <= 1'b0;
        end
      end else if (cnt_wr) begin
        cnt_q <= cnt_wdata;
      end else if (tick) begin
        if (ph_q == ph_top) begin
          ph_q    <= '0;
          cnt_q   <= cnt_n;
          dir_q   <= dir_n;
          pulse_q <= top_hit;
          if (ovf_set) ovf_q <= 1'b1;
        end else ph_q <= ph_q + PW'(1);
      end
    end
  end

  assign count        = cnt_q;
  assign period_pulse = pulse_q;
  assign ovf_flag     = ovf_q;
  assign ovf_irq      = ovf_q & ie_q;
  assign ctl_rdata    = {8'h00, ovf_q, ie_q, 1'b0, div_q, src_q, mode_q};

  a_r1_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_STOP && !ctl_wr && !cnt_wr) |=> cnt_q == $past(cnt_q));
  a_r3_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == M_UP || mode_q == M_UPDN) && limit == '0 && cnt_q == '0 && !ctl_wr && !cnt_wr)
    |=> cnt_q == '0);
  a_r2_pulse_mode: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> ((mode_q == M_UP && cnt_q == '0) || mode_q == M_UPDN));
  a_r4_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovf_q) && !$past(ctl_wr)) |-> cnt_q == '0);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[5]) |=> (cnt_q == '0 && ph_q == '0 && !pulse_q));
  a_r9_preload: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && !ctl_wr) |=> cnt_q == $past(cnt_wdata));
endmodule

// File: tb/test_tmr16_core.sv
module test_tmr16_core;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fast_tick = 0, slow_tick = 0, ctl_wr = 0, cnt_wr = 0;
  logic [15:0] ctl_wdata = '0, cnt_wdata = '0, limit = '0;
  logic [15:0] count, ctl_rdata;
  logic period_pulse, ovf_flag, ovf_irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_cnt = 0, m_ph = 0, m_mode = 0, m_div = 0;
  bit m_src = 0, m_ie = 0, m_ovf = 0, m_up = 1, m_pulse = 0;

  always #10 clk = ~clk;

  tmr16_core #(.CW(16)) i_tmr16_core (
    .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .slow_tick(slow_tick),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .limit(limit), .count(count), .ctl_rdata(ctl_rdata), .period_pulse(period_pulse),
    .ovf_flag(ovf_flag), .ovf_irq(ovf_irq));

  function automatic logic [15:0] mk(int mode, int src, int dv, int clr, int ie);
    return 16'((mode & 3) | ((src & 1) << 2) | ((dv & 3) << 3) | ((clr & 1) << 5) | ((ie & 1) << 6));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_count();
    int lim = int'(limit);
    case (m_mode)
      1: if (lim == 0) m_cnt = 0;
         else if (m_cnt >= lim) begin m_cnt = 0; m_ovf = 1; m_pulse = 1; end
         else m_cnt++;
      2: if (m_cnt == 65535) begin m_cnt = 0; m_ovf = 1; end else m_cnt++;
      3: if (lim == 0) begin m_cnt = 0; m_up = 1; end
         else if (m_up) begin
           if (m_cnt >= lim) begin
             m_cnt--;
             if (m_cnt == 0) m_ovf = 1; else m_up = 0;
           end else begin
             m_cnt++;
             if (m_cnt == lim) m_pulse = 1;
           end
         end else if (m_cnt == 0) m_up = 1;
         else begin
           m_cnt--;
           if (m_cnt == 0) begin m_ovf = 1; m_up = 1; end
         end
      default: ;
    endcase
  endtask

  task automatic model_step(input bit f, input bit s);
    m_pulse = 0;
    if (ctl_wr) begin
      m_mode = ctl_wdata[1:0]; m_src = ctl_wdata[2]; m_div = ctl_wdata[4:3];
      m_ie = ctl_wdata[6]; m_ovf = ctl_wdata[7]; m_ph = 0;
      if (ctl_wdata[5]) begin m_cnt = 0; m_up = 1; end
    end else if (cnt_wr) m_cnt = cnt_wdata;
    else if (m_src ? s : f) begin
      if (m_ph + 1 == (1 << m_div)) begin m_ph = 0; model_count(); end
      else m_ph++;
    end
  endtask

  task automatic cyc(input bit f, input bit s);
    fast_tick = f; slow_tick = s;
    @(posedge clk); #2;
    model_step(f, s);
    ctl_wr = 0; cnt_wr = 0; fast_tick = 0; slow_tick = 0;
    chk("model count", count, 32'(m_cnt));
    chk("model pulse", period_pulse, m_pulse);
    chk("model ovf", ovf_flag, m_ovf);
    chk("R10 irq", ovf_irq, m_ovf & m_ie);
    chk("R10 readback", ctl_rdata, {8'h00, m_ovf, m_ie, 1'b0, 2'(m_div), m_src, 2'(m_mode)});
  endtask

  task automatic wctl(input logic [15:0] v);
    ctl_wr = 1; ctl_wdata = v; cyc(0, 0);
  endtask

  task automatic wcnt(input logic [15:0] v);
    cnt_wr = 1; cnt_wdata = v; cyc(0, 0);
  endtask

  task automatic ticks(input int n, input bit f, input bit s);
    for (int i = 0; i < n; i++) cyc(f, s);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    chk("R1 reset count", count, 0);
    chk("R1 reset ctl", ctl_rdata, 0);

    // R1 halted
    limit = 100;
    wctl(mk(0, 0, 0, 1, 0));
    ticks(10, 1, 1);
    chk("R1 stop", count, 0);

    // R2 up mode period
    limit = 10;
    wctl(mk(1, 0, 0, 1, 1));
    ticks(10, 1, 0);
    chk("R2 at limit", count, 10);
    chk("R2 no ovf yet", ovf_flag, 0);
    ticks(1, 1, 0);
    chk("R2 wrap", count, 0);
    chk("R2 pulse", period_pulse, 1);
    chk("R2 ovf", ovf_flag, 1);
    chk("R10 irq on", ovf_irq, 1);
    ticks(1, 1, 0);
    chk("R2 pulse one cycle", period_pulse, 0);
    wctl(mk(1, 0, 0, 0, 1));
    chk("R10 flag cleared", ovf_flag, 0);
    chk("R10 count kept", count, 1);
    wctl(mk(1, 0, 0, 0, 0) | 16'h0080);
    chk("R10 flag written", ovf_flag, 1);
    chk("R10 irq gated", ovf_irq, 0);

    // R3 zero limit
    limit = 0;
    wctl(mk(1, 0, 0, 1, 0));
    ticks(10, 1, 0);
    chk("R3 up zero", count, 0);
    wctl(mk(3, 0, 0, 1, 0));
    ticks(10, 1, 0);
    chk("R3 updown zero", count, 0);
    wctl(mk(2, 0, 0, 1, 0));
    ticks(10, 1, 0);
    chk("R3 cont ignores zero", count, 10);

    // R4 / R9 wrap from preload
    wcnt(16'hFFFF);
    chk("R9 preload", count, 16'hFFFF);
    ticks(1, 1, 0);
    chk("R4 wrap", count, 0);
    chk("R4 ovf", ovf_flag, 1);
    cnt_wr = 1; cnt_wdata = 16'd5; cyc(1, 0);
    chk("R9 write beats tick", count, 5);

    // R5 up/down sequence
    limit = 3;
    wctl(mk(3, 0, 0, 1, 0));
    begin
      int exp_seq[7] = '{1, 2, 3, 2, 1, 0, 1};
      for (int i = 0; i < 7; i++) begin
        ticks(1, 1, 0);
        chk("R5 sequence", count, exp_seq[i]);
        if (i == 2) chk("R5 top pulse", period_pulse, 1);
        if (i == 5) chk("R5 ovf at zero", ovf_flag, 1);
      end
    end

    // R6 / R7 divider and source
    for (int d = 0; d < 4; d++) begin
      wctl(mk(2, 0, d, 1, 0));
      ticks(80, 1, 0);
      chk("R6 fast div", count, 80 >> d);
      ticks(100, 0, 1);
      chk("R7 slow ignored", count, 80 >> d);
      wctl(mk(2, 1, d, 1, 0));
      ticks(80, 0, 1);
      chk("R6 slow div", count, 80 >> d);
      ticks(100, 1, 0);
      chk("R7 fast ignored", count, 80 >> d);
    end

    // R8 clear resets phase
    wctl(mk(2, 0, 2, 1, 0));
    ticks(3, 1, 0);
    chk("R8 mid phase", count, 0);
    wctl(mk(2, 0, 2, 1, 0));
    chk("R8 clear reads 0", ctl_rdata[5], 0);
    ticks(3, 1, 0);
    chk("R8 phase reset", count, 0);
    ticks(1, 1, 0);
    chk("R8 first count", count, 1);
    ticks(2, 1, 0);
    wctl(mk(2, 0, 2, 0, 0));
    ticks(3, 1, 0);
    chk("R10 write resets phase", count, 1);
    ticks(1, 1, 0);
    chk("R10 phase count", count, 2);

    // random
    for (int i = 0; i < 5000; i++) begin
      int r = int'($urandom_range(0, 99));
      if ($urandom_range(0, 49) == 0) limit = 16'($urandom_range(0, 12));
      if (r < 3) begin
        ctl_wr = 1;
        ctl_wdata = 16'($urandom_range(0, 255));
      end else if (r < 5) begin
        cnt_wr = 1;
        cnt_wdata = ($urandom_range(0, 1) == 1) ? 16'($urandom_range(16'hFFF0, 16'hFFFF))
                                                 : 16'($urandom_range(0, 14));
      end
      cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    finish_run();
  end
endmodule